// File: doc/BRIEF.md
# Scatter-Gather Stream Transmit Channel

This block is the transmit half of a descriptor-driven DMA engine. Software sets a current-descriptor pointer and a tail-descriptor pointer and raises run through a small 32-bit register window. The channel then walks a linked list of descriptors over a single-outstanding memory port. For each descriptor it reads the control word, the status word, the buffer address and the next-descriptor pointer, in that order. On a start-of-frame descriptor it first sends the five application words on a control stream. It then reads the buffer word by word and sends the words on a data stream, and finally writes the status word back with the complete bit set.

A packet may span several descriptors. The end-of-frame descriptor carries the final beat with TLAST, and finishing it raises a completion flag that can drive the interrupt line. The channel stops once the tail descriptor has been written back and then shows idle. If it fetches a descriptor whose complete bit is already set, it stops and shows halted.

Descriptor layout, as byte offsets from the descriptor address: next pointer at 0x00, buffer address at 0x08, control at 0x18, status at 0x1C, and application words at 0x20 to 0x30. Only the low 32 bits of each pointer are used. Buffers are word aligned.

Top module: `sg_tx_dma`

## Requirements
- R1: After reset the status register (offset 0x04) reads idle set (bit 1) and halted clear (bit 0). Control, current pointer and tail pointer read 0. Both stream valids, mem_req and irq are low.
- R2: Control (0x00), current pointer (0x08) and tail pointer (0x10) read back the last value written. Reads of unmapped offsets return 0. Read data appears one cycle after reg_rd.
- R3: A write to the tail pointer clears the idle flag. Processing starts only while run (control bit 0) is 1; with run at 0 the memory port stays quiet.
- R4: A descriptor with start-of-frame (control bit 27) first emits its five application words, in address order, on the control stream. TLAST marks the fifth word, and all five come before any data beat of that descriptor.
- R5: The length in bytes is control bits [22:0]. Buffer words are sent in ascending address order, and tkeep marks the valid low bytes of a final partial word.
- R6: TLAST on the data stream is set only on the last beat of an end-of-frame descriptor (control bit 26). An end-of-frame descriptor of length 0 emits one beat with tkeep 0 and TLAST 1.
- R7: Each processed descriptor's status word is written to offset 0x1C with bit 31 set and bits [22:0] equal to its length, before the next descriptor is fetched.
- R8: After the descriptor equal to the tail pointer is written back, idle is set, the current pointer reads the tail, and descriptors beyond the tail are untouched.
- R9: A fetched descriptor whose status bit 31 is already set halts the channel. Halted is set, nothing is emitted, nothing is written, and the current pointer stays on that descriptor. Writing control with run at 1 clears halted.
- R10: Completing an end-of-frame descriptor sets status bit 12. Writing 1 to that bit clears it. irq is high exactly while bit 12 and enable (control bit 12) are both set.
- R11: Under TREADY backpressure the data and control streams hold their beat stable until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after reg_rd |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | Memory write when high |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge pulse |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| tx_tvalid | output | 1 | Data stream valid |
| tx_tready | input | 1 | Data stream ready |
| tx_tdata | output | 32 | Data stream payload |
| tx_tkeep | output | 4 | Data stream byte enables |
| tx_tlast | output | 1 | Data stream end of packet |
| ctl_tvalid | output | 1 | Control stream valid |
| ctl_tready | input | 1 | Control stream ready |
| ctl_tdata | output | 32 | Control stream application word |
| ctl_tlast | output | 1 | Control stream last application word |
| irq | output | 1 | Completion interrupt |

## Verification
The bench uses the default 32-bit data and address widths and a 23-bit length field. A four-byte word then makes every tkeep pattern reachable with buffers of at most nine bytes. Single-descriptor packets are swept over every length from 0 to 9, which covers the zero-length beat, each partial final word and multi-beat buffers. Short chains cover a packet split across two descriptors with partial words in both, a stop at a tail placed before the end of the list, interrupt masking and clearing, and a halt on a descriptor that is already complete. Both ready inputs toggle pseudo-randomly throughout.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;
  localparam int DESC_NEXT = 0;
  localparam int DESC_BUF  = 8;
  localparam int DESC_CTRL = 24;
  localparam int DESC_STAT = 28;
  localparam int DESC_APP  = 32;
  localparam int APP_WORDS = 5;

  localparam int CW_SOF  = 27;
  localparam int CW_EOF  = 26;
  localparam int SW_DONE = 31;

  localparam int RG_CTRL = 0;
  localparam int RG_STAT = 4;
  localparam int RG_CUR  = 8;
  localparam int RG_TAIL = 16;

  localparam int CR_RUN   = 0;
  localparam int CR_IRQEN = 12;
  localparam int SR_HALT  = 0;
  localparam int SR_IDLE  = 1;
  localparam int SR_IRQ   = 12;

  typedef enum logic [3:0] {
    W_IDLE, W_RD_CTRL, W_RD_STAT, W_RD_BUF, W_RD_NEXT, W_RD_APP, W_PUSH_APP,
    W_RD_DATA, W_PUSH_DATA, W_ZERO_LAST, W_WR_STAT, W_ADVANCE
  } walk_state_t;
endpackage

// File: rtl/sg_tx_regs.sv
module sg_tx_regs
  import sgdma_pkg::*;
#(
  parameter int RAW = 6,
  parameter int DW  = 32,
  parameter int AW  = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr,
  input  logic           rd,
  input  logic [RAW-1:0] addr,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata,
  input  logic           done_p,
  input  logic           halt_p,
  input  logic           cmpl_p,
  input  logic           cur_upd,
  input  logic [AW-1:0]  cur_nxt,
  output logic           run,
  output logic [AW-1:0]  cur_ptr,
  output logic [AW-1:0]  tail_ptr,
  output logic           idle,
  output logic           halted,
  output logic           irq
);
  logic [DW-1:0] ctrl_q;
  logic          flag_q;
  logic [DW-1:0] stat_w;

  always_comb begin
    stat_w = '0;
    stat_w[SR_HALT] = halted;
    stat_w[SR_IDLE] = idle;
    stat_w[SR_IRQ]  = flag_q;
  end

  assign run = ctrl_q[CR_RUN];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      cur_ptr  <= '0;
      tail_ptr <= '0;
      idle     <= 1'b1;
      halted   <= 1'b0;
      flag_q   <= 1'b0;
      irq      <= 1'b0;
      rdata    <= '0;
    end else begin
      if (cur_upd) cur_ptr <= cur_nxt;
      if (done_p)  idle    <= 1'b1;
      if (wr) begin
        case (int'(addr))
          RG_CTRL: begin
            ctrl_q <= wdata;
            if (wdata[CR_RUN]) halted <= 1'b0;
          end
          RG_STAT: if (wdata[SR_IRQ]) flag_q <= 1'b0;
          RG_CUR:  cur_ptr <= wdata[AW-1:0];
          RG_TAIL: begin
            tail_ptr <= wdata[AW-1:0];
            idle     <= 1'b0;
          end
          default: ;
        endcase
      end
      if (halt_p) halted <= 1'b1;
      if (cmpl_p) flag_q <= 1'b1;
      irq <= flag_q & ctrl_q[CR_IRQEN];
      if (rd) begin
        case (int'(addr))
          RG_CTRL: rdata <= ctrl_q;
          RG_STAT: rdata <= stat_w;
          RG_CUR:  rdata <= DW'(cur_ptr);
          RG_TAIL: rdata <= DW'(tail_ptr);
          default: rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/sg_tx_walker.sv
module sg_tx_walker
  import sgdma_pkg::*;
#(
  parameter int DW    = 32,
  parameter int AW    = 32,
  parameter int LEN_W = 23
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            enable,
  input  logic            run,
  input  logic [AW-1:0]   cur_in,
  input  logic [AW-1:0]   tail_in,
  output logic            done_p,
  output logic            halt_p,
  output logic            cmpl_p,
  output logic            cur_upd,
  output logic [AW-1:0]   cur_nxt,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic            mem_ack,
  input  logic [DW-1:0]   mem_rdata,
  output logic            d_valid,
  input  logic            d_ready,
  output logic [DW-1:0]   d_data,
  output logic [DW/8-1:0] d_keep,
  output logic            d_last,
  output logic            c_valid,
  input  logic            c_ready,
  output logic [DW-1:0]   c_data,
  output logic            c_last
);
  localparam int BYTES = DW / 8;
  localparam int BSH   = $clog2(BYTES);
  localparam int AIW   = $clog2(APP_WORDS);

  walk_state_t     st;
  logic [AW-1:0]   cur, nxt_p, buf_p;
  logic [LEN_W-1:0] len_q, rem;
  logic            sof_q, eof_q;
  logic [AIW-1:0]  app_idx;
  logic [AW-1:0]   addr_c;
  logic            mem_st;
  logic [BYTES-1:0] keep_c;
  logic            rem_tail;
  walk_state_t     after_hdr;
  logic [DW-1:0]   stat_wb;

  always_comb begin
    case (st)
      W_RD_CTRL: addr_c = cur + AW'(DESC_CTRL);
      W_RD_STAT,
      W_WR_STAT: addr_c = cur + AW'(DESC_STAT);
      W_RD_BUF:  addr_c = cur + AW'(DESC_BUF);
      W_RD_NEXT: addr_c = cur + AW'(DESC_NEXT);
      W_RD_APP:  addr_c = cur + AW'(DESC_APP) + (AW'(app_idx) << BSH);
      W_RD_DATA: addr_c = buf_p;
      default:   addr_c = cur;
    endcase
  end

  assign mem_st = (st == W_RD_CTRL) || (st == W_RD_STAT) || (st == W_RD_BUF) ||
                  (st == W_RD_NEXT) || (st == W_RD_APP)  || (st == W_RD_DATA) ||
                  (st == W_WR_STAT);

  genvar gi;
  generate
    for (gi = 0; gi < BYTES; gi++) begin : g_keep
      assign keep_c[gi] = (rem > LEN_W'(gi));
    end
  endgenerate

  assign rem_tail  = (rem <= LEN_W'(BYTES));
  assign stat_wb   = DW'(len_q) | (DW'(1) << SW_DONE);

  always_comb begin
    if (len_q != '0)  after_hdr = W_RD_DATA;
    else if (eof_q)   after_hdr = W_ZERO_LAST;
    else              after_hdr = W_WR_STAT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= W_IDLE;
      cur <= '0; nxt_p <= '0; buf_p <= '0;
      len_q <= '0; rem <= '0; sof_q <= 1'b0; eof_q <= 1'b0; app_idx <= '0;
      done_p <= 1'b0; halt_p <= 1'b0; cmpl_p <= 1'b0;
      cur_upd <= 1'b0; cur_nxt <= '0;
      mem_req <= 1'b0; mem_we <= 1'b0; mem_addr <= '0; mem_wdata <= '0;
      d_valid <= 1'b0; d_data <= '0; d_keep <= '0; d_last <= 1'b0;
      c_valid <= 1'b0; c_data <= '0; c_last <= 1'b0;
    end else begin
      done_p  <= 1'b0;
      halt_p  <= 1'b0;
      cmpl_p  <= 1'b0;
      cur_upd <= 1'b0;
      if (mem_st && !mem_req) begin
        mem_req   <= 1'b1;
        mem_addr  <= addr_c;
        mem_we    <= (st == W_WR_STAT);
        mem_wdata <= stat_wb;
      end else if (mem_st && mem_ack) begin
        mem_req <= 1'b0;
        mem_we  <= 1'b0;
        case (st)
          W_RD_CTRL: begin
            len_q <= mem_rdata[LEN_W-1:0];
            sof_q <= mem_rdata[CW_SOF];
            eof_q <= mem_rdata[CW_EOF];
            st    <= W_RD_STAT;
          end
          W_RD_STAT: begin
            if (mem_rdata[SW_DONE]) begin
              halt_p <= 1'b1;
              st     <= W_IDLE;
            end else begin
              st <= W_RD_BUF;
            end
          end
          W_RD_BUF: begin
            buf_p <= mem_rdata[AW-1:0];
            st    <= W_RD_NEXT;
          end
          W_RD_NEXT: begin
            nxt_p   <= mem_rdata[AW-1:0];
            rem     <= len_q;
            app_idx <= '0;
            st      <= sof_q ? W_RD_APP : after_hdr;
          end
          W_RD_APP: begin
            c_valid <= 1'b1;
            c_data  <= mem_rdata;
            c_last  <= (app_idx == AIW'(APP_WORDS - 1));
            st      <= W_PUSH_APP;
          end
          W_RD_DATA: begin
            d_valid <= 1'b1;
            d_data  <= mem_rdata;
            d_keep  <= keep_c;
            d_last  <= eof_q && rem_tail;
            st      <= W_PUSH_DATA;
          end
          W_WR_STAT: begin
            if (eof_q) cmpl_p <= 1'b1;
            if (cur == tail_in) begin
              done_p <= 1'b1;
              st     <= W_IDLE;
            end else begin
              cur     <= nxt_p;
              cur_nxt <= nxt_p;
              cur_upd <= 1'b1;
              st      <= W_ADVANCE;
            end
          end
          default: st <= W_IDLE;
        endcase
      end else begin
        case (st)
          W_IDLE: begin
            if (enable && !done_p && !halt_p) begin
              cur <= cur_in;
              st  <= W_RD_CTRL;
            end
          end
          W_PUSH_APP: begin
            if (c_ready) begin
              c_valid <= 1'b0;
              c_last  <= 1'b0;
              if (app_idx == AIW'(APP_WORDS - 1)) st <= after_hdr;
              else begin
                app_idx <= app_idx + 1'b1;
                st      <= W_RD_APP;
              end
            end
          end
          W_PUSH_DATA: begin
            if (d_ready) begin
              d_valid <= 1'b0;
              d_last  <= 1'b0;
              buf_p   <= buf_p + AW'(BYTES);
              if (rem_tail) begin
                rem <= '0;
                st  <= W_WR_STAT;
              end else begin
                rem <= rem - LEN_W'(BYTES);
                st  <= W_RD_DATA;
              end
            end
          end
          W_ZERO_LAST: begin
            if (!d_valid) begin
              d_valid <= 1'b1;
              d_data  <= '0;
              d_keep  <= '0;
              d_last  <= 1'b1;
            end else if (d_ready) begin
              d_valid <= 1'b0;
              d_last  <= 1'b0;
              st      <= W_WR_STAT;
            end
          end
          W_ADVANCE: st <= run ? W_RD_CTRL : W_IDLE;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/sg_tx_dma.sv
module sg_tx_dma
  import sgdma_pkg::*;
#(
  parameter int RAW   = 6,
  parameter int DW    = 32,
  parameter int AW    = 32,
  parameter int LEN_W = 23
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [RAW-1:0]  reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic            mem_ack,
  input  logic [DW-1:0]   mem_rdata,
  output logic            tx_tvalid,
  input  logic            tx_tready,
  output logic [DW-1:0]   tx_tdata,
  output logic [DW/8-1:0] tx_tkeep,
  output logic            tx_tlast,
  output logic            ctl_tvalid,
  input  logic            ctl_tready,
  output logic [DW-1:0]   ctl_tdata,
  output logic            ctl_tlast,
  output logic            irq
);
  logic          done_p, halt_p, cmpl_p, cur_upd, run;
  logic [AW-1:0] cur_nxt, cur_ptr, tail_ptr;
  logic          idle_flag, halted_flag;

  sg_tx_regs #(.RAW(RAW), .DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .done_p(done_p), .halt_p(halt_p),
    .cmpl_p(cmpl_p), .cur_upd(cur_upd), .cur_nxt(cur_nxt), .run(run),
    .cur_ptr(cur_ptr), .tail_ptr(tail_ptr), .idle(idle_flag),
    .halted(halted_flag), .irq(irq)
  );

  sg_tx_walker #(.DW(DW), .AW(AW), .LEN_W(LEN_W)) u_walk (
    .clk(clk), .rst(rst), .enable(run & ~idle_flag & ~halted_flag), .run(run),
    .cur_in(cur_ptr), .tail_in(tail_ptr), .done_p(done_p), .halt_p(halt_p),
    .cmpl_p(cmpl_p), .cur_upd(cur_upd), .cur_nxt(cur_nxt),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .d_valid(tx_tvalid), .d_ready(tx_tready), .d_data(tx_tdata),
    .d_keep(tx_tkeep), .d_last(tx_tlast), .c_valid(ctl_tvalid),
    .c_ready(ctl_tready), .c_data(ctl_tdata), .c_last(ctl_tlast)
  );
endmodule

// File: rtl/sg_tx_dma_chk.sv
module sg_tx_dma_chk #(
  parameter int DW = 32,
  parameter int AW = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            mem_req,
  input logic            mem_we,
  input logic [AW-1:0]   mem_addr,
  input logic [DW-1:0]   mem_wdata,
  input logic            mem_ack,
  input logic            tx_tvalid,
  input logic            tx_tready,
  input logic [DW-1:0]   tx_tdata,
  input logic [DW/8-1:0] tx_tkeep,
  input logic            tx_tlast,
  input logic            ctl_tvalid,
  input logic            ctl_tready,
  input logic [DW-1:0]   ctl_tdata,
  input logic            ctl_tlast,
  input logic            idle_flag,
  input logic            halted_flag
);
  p_mem_hold_r7: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  p_data_hold_r11: assert property (@(posedge clk) disable iff (rst)
    tx_tvalid && !tx_tready |=> tx_tvalid && $stable(tx_tdata) && $stable(tx_tkeep) && $stable(tx_tlast));

  p_ctl_hold_r11: assert property (@(posedge clk) disable iff (rst)
    ctl_tvalid && !ctl_tready |=> ctl_tvalid && $stable(ctl_tdata) && $stable(ctl_tlast));

  p_one_stream_r4: assert property (@(posedge clk) disable iff (rst)
    !(tx_tvalid && ctl_tvalid));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    idle_flag |-> !mem_req);

  p_halt_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    halted_flag |-> !mem_req && !tx_tvalid && !ctl_tvalid);
endmodule

bind sg_tx_dma sg_tx_dma_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
  .tx_tvalid(tx_tvalid), .tx_tready(tx_tready), .tx_tdata(tx_tdata),
  .tx_tkeep(tx_tkeep), .tx_tlast(tx_tlast), .ctl_tvalid(ctl_tvalid),
  .ctl_tready(ctl_tready), .ctl_tdata(ctl_tdata), .ctl_tlast(ctl_tlast),
  .idle_flag(idle_flag), .halted_flag(halted_flag)
);

// File: tb/sim_sg_tx_dma.sv
`timescale 1ns/1ps
module sim_sg_tx_dma;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic        tx_tvalid, tx_tready = 1'b0, tx_tlast;
  logic [31:0] tx_tdata;
  logic [3:0]  tx_tkeep;
  logic        ctl_tvalid, ctl_tready = 1'b0, ctl_tlast;
  logic [31:0] ctl_tdata;
  logic        irq;

  always #4 clk = ~clk;

  sg_tx_dma u0 (.*);

  int n_tests = 0, n_fail = 0;
  logic [31:0] mem [128];
  int          mem_starts = 0;
  logic [31:0] d_data [32]; logic [3:0] d_keep [32]; logic d_last [32]; int d_seq [32];
  logic [31:0] c_data [32]; logic c_last [32]; int c_seq [32];
  int          d_n = 0, c_n = 0, seq = 0;
  logic [7:0]  lfsr = 8'h5A;

  always @(posedge clk) begin
    mem_ack <= mem_req && !mem_ack;
    if (mem_req && !mem_ack) begin
      mem_starts <= mem_starts + 1;
      if (mem_we) mem[mem_addr[8:2]] <= mem_wdata;
      mem_rdata <= mem[mem_addr[8:2]];
    end
    if (tx_tvalid && tx_tready && d_n < 32) begin
      d_data[d_n] <= tx_tdata; d_keep[d_n] <= tx_tkeep; d_last[d_n] <= tx_tlast;
      d_seq[d_n] <= seq; d_n <= d_n + 1; seq <= seq + 1;
    end
    if (ctl_tvalid && ctl_tready && c_n < 32) begin
      c_data[c_n] <= ctl_tdata; c_last[c_n] <= ctl_tlast;
      c_seq[c_n] <= seq; c_n <= c_n + 1; seq <= seq + 1;
    end
  end

  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    tx_tready  <= lfsr[0] | lfsr[2];
    ctl_tready <= lfsr[1] | lfsr[4];
  end

  initial begin
    #1600000;
    n_tests++; n_fail++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic rwr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rrd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  function automatic logic [31:0] bufpat(input int a);
    return 32'hA500_0000 | a;
  endfunction
  function automatic logic [31:0] apppat(input int base, input int i);
    return 32'hC000_0000 | (base << 4) | i;
  endfunction

  task automatic put_desc(input int base, input int nxt, input int bufa,
                          input logic [31:0] ctl, input logic [31:0] sts);
    int w = base / 4;
    mem[w] = nxt; mem[w+1] = 0; mem[w+2] = bufa; mem[w+3] = 0;
    mem[w+4] = 0; mem[w+5] = 0; mem[w+6] = ctl; mem[w+7] = sts;
    for (int i = 0; i < 5; i++) mem[w+8+i] = apppat(base, i);
  endtask

  task automatic clear_logs();
    @(negedge clk); d_n = 0; c_n = 0; seq = 0;
  endtask

  task automatic wait_stop(input string tag);
    logic [31:0] s;
    int k = 0;
    s = 0;
    while (k < 2000 && s[1:0] == 2'b00) begin rrd(6'h04, s); k++; end
    chk(k < 2000, {tag, " stop reached"}, s, 32'h2);
    repeat (4) @(negedge clk);
  endtask

  task automatic check_packet(input string tag, input int base, input int bufa, input int len);
    int beats = (len == 0) ? 1 : (len + 3) / 4;
    chk(c_n == 5, {tag, " R4 ctl beat count"}, c_n, 5);
    for (int i = 0; i < 5; i++) begin
      chk(c_data[i] == apppat(base, i), {tag, " R4 app word"}, c_data[i], apppat(base, i));
      chk(c_last[i] == (i == 4), {tag, " R4 ctl last"}, c_last[i], (i == 4));
    end
    chk(d_n == beats, {tag, " R5 beat count"}, d_n, beats);
    chk(c_seq[4] < d_seq[0], {tag, " R4 app before data"}, c_seq[4], d_seq[0]);
    for (int k = 0; k < beats; k++) begin
      int r = len - 4 * k;
      logic [3:0] ek = (len == 0) ? 4'h0 : (r >= 4) ? 4'hF : 4'((1 << r) - 1);
      chk(d_keep[k] == ek, {tag, " R5 keep"}, d_keep[k], ek);
      chk(d_last[k] == (k == beats - 1), {tag, " R6 last"}, d_last[k], (k == beats - 1));
      if (len > 0) chk(d_data[k] == bufpat(bufa + 4 * k), {tag, " R5 data"}, d_data[k], bufpat(bufa + 4 * k));
    end
    chk(mem[(base + 28) / 4] == (32'h8000_0000 | len), {tag, " R7 writeback"},
        mem[(base + 28) / 4], 32'h8000_0000 | len);
  endtask

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 128; i++) mem[i] = bufpat(i * 4);
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk(!tx_tvalid && !ctl_tvalid && !mem_req && !irq, "R1 outputs low", {tx_tvalid, ctl_tvalid, mem_req, irq}, 0);
    rrd(6'h04, v); chk(v == 32'h2, "R1 status", v, 32'h2);
    rrd(6'h00, v); chk(v == 0, "R1 control", v, 0);
    rrd(6'h08, v); chk(v == 0, "R1 cur", v, 0);
    rrd(6'h10, v); chk(v == 0, "R1 tail", v, 0);

    // R2 readback
    rwr(6'h08, 32'h0000_0040); rrd(6'h08, v); chk(v == 32'h40, "R2 cur", v, 32'h40);
    rwr(6'h00, 32'h0000_0002); rrd(6'h00, v); chk(v == 32'h2, "R2 control", v, 32'h2);
    rrd(6'h0C, v); chk(v == 0, "R2 unmapped", v, 0);
    rrd(6'h30, v); chk(v == 0, "R2 outside window", v, 0);

    // R3 run clear: tail write clears idle but nothing moves
    put_desc(0, 0, 32'h100, 32'h0C00_0004, 0);
    rwr(6'h08, 0);
    clear_logs();
    mem_starts = 0;
    rwr(6'h10, 0);
    repeat (40) @(negedge clk);
    rrd(6'h04, v); chk(v[1] == 1'b0, "R3 idle cleared", v, 0);
    chk(mem_starts == 0, "R3 no memory access when stopped", mem_starts, 0);
    rwr(6'h00, 32'h1);
    wait_stop("R3");
    check_packet("R3 start on run", 0, 32'h100, 4);

    // Sweep of single-descriptor packets, lengths 0..9
    for (int len = 0; len <= 9; len++) begin
      put_desc(0, 0, 32'h100, 32'h0C00_0000 | len, 0);
      rwr(6'h08, 0);
      clear_logs();
      rwr(6'h10, 0);
      wait_stop("sweep");
      check_packet($sformatf("len%0d", len), 0, 32'h100, len);
      rrd(6'h08, v); chk(v == 0, "R8 cur on tail", v, 0);
    end

    // R10 flag set but masked
    rrd(6'h04, v); chk(v[12] == 1'b1, "R10 flag set", v, 32'h1000);
    chk(irq == 1'b0, "R10 irq masked", irq, 0);
    rwr(6'h04, 32'h1000);
    rrd(6'h04, v); chk(v[12] == 1'b0, "R10 W1C", v, 0);

    // Packet split over two descriptors: R6 last only on EOF, R5 partial words
    put_desc(0, 32'h40, 32'h100, 32'h0800_0006, 0);
    put_desc(32'h40, 0, 32'h120, 32'h0400_0005, 0);
    rwr(6'h08, 0);
    clear_logs();
    rwr(6'h10, 32'h40);
    wait_stop("split");
    chk(c_n == 5, "R4 one app set per packet", c_n, 5);
    chk(d_n == 4, "R5 split beats", d_n, 4);
    if (d_n == 4) begin
      chk({d_keep[0], d_keep[1], d_keep[2], d_keep[3]} == 16'hF3F1, "R5 split keeps",
          {d_keep[0], d_keep[1], d_keep[2], d_keep[3]}, 16'hF3F1);
      chk({d_last[0], d_last[1], d_last[2], d_last[3]} == 4'b0001, "R6 split last",
          {d_last[0], d_last[1], d_last[2], d_last[3]}, 4'b0001);
      chk(d_data[2] == bufpat(32'h120), "R5 second buffer", d_data[2], bufpat(32'h120));
    end
    chk(mem[7] == 32'h8000_0006, "R7 first writeback", mem[7], 32'h8000_0006);
    chk(mem[23] == 32'h8000_0005, "R7 second writeback", mem[23], 32'h8000_0005);
    rrd(6'h08, v); chk(v == 32'h40, "R8 cur after split", v, 32'h40);

    // R8 tail before end of list, R10 interrupt enabled
    rwr(6'h04, 32'h1000);
    rwr(6'h00, 32'h1001);
    put_desc(0, 32'h40, 32'h100, 32'h0C00_0004, 0);
    put_desc(32'h40, 32'h80, 32'h110, 32'h0C00_0003, 0);
    put_desc(32'h80, 0, 32'h120, 32'h0C00_0002, 0);
    rwr(6'h08, 0);
    clear_logs();
    rwr(6'h10, 32'h40);
    wait_stop("chain");
    chk(c_n == 10 && d_n == 2, "R8 chain beats", {c_n[15:0], d_n[15:0]}, {16'd10, 16'd2});
    chk(mem[39] == 0, "R8 beyond tail untouched", mem[39], 0);
    chk(mem[23] == 32'h8000_0003, "R7 chain writeback", mem[23], 32'h8000_0003);
    rrd(6'h08, v); chk(v == 32'h40, "R8 cur equals tail", v, 32'h40);
    rrd(6'h04, v); chk(v[1] == 1'b1, "R8 idle", v, 32'h2);
    chk(irq == 1'b1, "R10 irq high", irq, 1);
    rwr(6'h04, 32'h1000);
    repeat (2) @(negedge clk);
    chk(irq == 1'b0, "R10 irq cleared", irq, 0);

    // R9 halt on already complete descriptor
    put_desc(32'h80, 0, 32'h120, 32'h0C00_0002, 32'h8000_0000);
    rwr(6'h08, 32'h80);
    clear_logs();
    rwr(6'h10, 32'h80);
    wait_stop("halt");
    rrd(6'h04, v); chk(v[0] == 1'b1 && v[1] == 1'b0, "R9 halted", v, 32'h1);
    chk(c_n == 0 && d_n == 0, "R9 nothing emitted", {c_n[15:0], d_n[15:0]}, 0);
    chk(mem[39] == 32'h8000_0000, "R9 no writeback", mem[39], 32'h8000_0000);
    rrd(6'h08, v); chk(v == 32'h80, "R9 cur kept", v, 32'h80);
    mem[39] = 0;
    rwr(6'h00, 32'h1);
    rrd(6'h04, v); chk(v[0] == 1'b0, "R9 run clears halt", v, 0);
    wait_stop("resume");
    check_packet("R9 resume", 32'h80, 32'h120, 2);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule